// File: doc/BRIEF.md
# Stall-Address Reservoir Sampler

The block watches a stream of pipeline stall events. Each event carries the address of the stalled instruction and the index of the source operand that was not ready. The block keeps one of those events as a sample. It aims for every event since the last clear to have roughly the same chance of being the one held. Stall detection is done elsewhere. The block only receives events that have already been qualified.

An event counter tracks how many events have arrived. When event number n arrives, a mask is built with ones in every bit position below the most significant set bit of n. The mask is ANDed with a free-running 32-bit LFSR. If the result is zero, the new event replaces the held one. Event n is therefore kept with probability 1/2^floor(log2 n). This is a cheap, power-of-two approximation of the exact 1/n rule. Software reads the held address, operand index, valid flag and event count from the output ports, and starts a new sampling window with a one-cycle clear.

Top module: `stall_sampler`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the count, valid flag, held address and held operand index are all zero.
- R2: An event that arrives without a clear raises the count by exactly one, visible on the cycle after the event.
- R3: The count saturates at 2^CNT_W-1. Further events leave it at that value and do not wrap it to zero.
- R4: The first event after reset or clear is always captured. On the next cycle the valid flag is 1 and the held address and operand index equal the event's.
- R5: For every other event, let n be the count after increment and saturation, and let mask have ones at all bit positions below the top set bit of n. The event replaces the held sample exactly when (LFSR[CNT_W-1:0] & mask) == 0, using the LFSR value present at that clock edge.
- R6: The generator is a 32-bit register that loads SEED (nonzero) in reset. On every later cycle it shifts left by one bit, and its new bit 0 is bit31 ^ bit21 ^ bit1 ^ bit0. It never holds zero.
- R7: The held address and operand index are always written together. In a cycle with no event and no clear, all four outputs hold their values.
- R8: A clear zeroes the count, valid flag, address and operand index on the next cycle. It takes priority over an event in the same cycle, and that event is dropped.
- R9: Once set, the valid flag stays 1 until a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ev_valid_i | input | 1 | A stall event is present this cycle |
| ev_addr_i | input | ADDR_W | Address of the stalled instruction |
| ev_opidx_i | input | OP_W | Index of the operand that was not ready |
| clr_i | input | 1 | Clears count and sample, starting a new window |
| smp_addr_o | output | ADDR_W | Held sample address |
| smp_opidx_o | output | OP_W | Held sample operand index |
| smp_valid_o | output | 1 | A sample is held |
| ev_count_o | output | CNT_W | Events since clear, saturating |

## Verification
The bench runs a reference generator and its own mask rule, so that every replacement decision is predicted exactly. A mask that is one bit too wide or too narrow, or a generator tapped or shifted wrongly, would keep a different event at some point in the run. The bench uses a narrow counter to drive the count past its ceiling, where a wrapping design would drop to zero and then force a capture. It also applies a clear in the same cycle as an event. A design that let the event win would show count 1 and a valid sample instead of an empty state.

// File: rtl/stall_sampler_pkg.sv
package stall_sampler_pkg;
    localparam int unsigned GEN_W = 32;

    // Maximal-length feedback taps at positions 32, 22, 2, 1 (1-based).
    function automatic logic [GEN_W-1:0] gen_step(input logic [GEN_W-1:0] s);
        return {s[GEN_W-2:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
    endfunction
endpackage

// File: rtl/stall_sampler_gen.sv
module stall_sampler_gen
    import stall_sampler_pkg::*;
#(
    parameter logic [GEN_W-1:0] SEED = 32'h1ACE_B00C
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    output logic [GEN_W-1:0] rnd_o
);
    logic [GEN_W-1:0] rnd_d, rnd_q;

    always_comb begin
        rnd_d = gen_step(rnd_q);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) rnd_q <= SEED;
        else         rnd_q <= rnd_d;
    end

    assign rnd_o = rnd_q;

    // R6: a nonzero seed never reaches the lock-up state
    p_gen_nonzero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rnd_q != '0);
    // R6: each cycle is a one-bit left shift of the previous state
    p_gen_shift_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_ni && $past(rst_ni) |-> rnd_q[GEN_W-1:1] == $past(rnd_q[GEN_W-2:0]));
endmodule

// File: rtl/stall_sampler_mask.sv
module stall_sampler_mask #(
    parameter int unsigned CNT_W = 16
) (
    input  logic [CNT_W-1:0] n_i,
    output logic [CNT_W-1:0] mask_o
);
    // Ones in every position below the highest set bit of n_i.
    always_comb begin
        mask_o = '0;
        for (int unsigned i = 1; i < CNT_W; i++) begin
            if (n_i[i]) mask_o = CNT_W'((64'd1 << i) - 64'd1);
        end
    end
endmodule

// File: rtl/stall_sampler.sv
module stall_sampler
    import stall_sampler_pkg::*;
#(
    parameter int unsigned      ADDR_W = 32,
    parameter int unsigned      OP_W   = 2,
    parameter int unsigned      CNT_W  = 16,
    parameter logic [GEN_W-1:0] SEED   = 32'h1ACE_B00C
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ev_valid_i,
    input  logic [ADDR_W-1:0] ev_addr_i,
    input  logic [OP_W-1:0]   ev_opidx_i,
    input  logic              clr_i,
    output logic [ADDR_W-1:0] smp_addr_o,
    output logic [OP_W-1:0]   smp_opidx_o,
    output logic              smp_valid_o,
    output logic [CNT_W-1:0]  ev_count_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic              vld;
        logic [ADDR_W-1:0] addr;
        logic [OP_W-1:0]   op;
    } state_t;

    state_t           st_d, st_q;
    logic [GEN_W-1:0] rnd;
    logic [CNT_W-1:0] n_next, mask;
    logic             take;

    stall_sampler_gen #(.SEED(SEED)) u_gen (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .rnd_o (rnd)
    );

    stall_sampler_mask #(.CNT_W(CNT_W)) u_mask (
        .n_i   (n_next),
        .mask_o(mask)
    );

    always_comb begin
        n_next = (st_q.cnt == CNT_MAX) ? CNT_MAX : st_q.cnt + 1'b1;
        take   = (rnd[CNT_W-1:0] & mask) == '0;
        st_d   = st_q;
        if (clr_i) begin
            st_d = '0;
        end else if (ev_valid_i) begin
            st_d.cnt = n_next;
            if (take) begin
                st_d.vld  = 1'b1;
                st_d.addr = ev_addr_i;
                st_d.op   = ev_opidx_i;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign smp_addr_o  = st_q.addr;
    assign smp_opidx_o = st_q.op;
    assign smp_valid_o = st_q.vld;
    assign ev_count_o  = st_q.cnt;

    p_count_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ev_valid_i && !clr_i && ev_count_o != CNT_MAX |=> ev_count_o == $past(ev_count_o) + 1'b1);
    p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ev_valid_i && !clr_i && ev_count_o == CNT_MAX |=> ev_count_o == CNT_MAX);
    p_first_capture_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ev_valid_i && !clr_i && ev_count_o == '0 |=>
            smp_valid_o && smp_addr_o == $past(ev_addr_i) && smp_opidx_o == $past(ev_opidx_i));
    p_idle_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ev_valid_i && !clr_i |=> $stable(smp_addr_o) && $stable(smp_opidx_o)
            && $stable(smp_valid_o) && $stable(ev_count_o));
    p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> ev_count_o == '0 && !smp_valid_o && smp_addr_o == '0);
    p_valid_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        smp_valid_o && !clr_i |=> smp_valid_o);
endmodule

// File: tb/stall_sampler_tb_top.sv
module stall_sampler_tb_top;
    localparam int unsigned ADDR_W = 32;
    localparam int unsigned OP_W   = 2;
    localparam int unsigned CNT_W  = 4;
    localparam logic [31:0] SEED   = 32'h1ACE_B00C;
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ev_v = 1'b0;
    logic [ADDR_W-1:0] ev_a = '0;
    logic [OP_W-1:0]   ev_o = '0;
    logic              clr = 1'b0;
    logic [ADDR_W-1:0] s_a;
    logic [OP_W-1:0]   s_o;
    logic              s_v;
    logic [CNT_W-1:0]  s_c;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2ns clk = ~clk;  // 250 MHz

    stall_sampler #(.ADDR_W(ADDR_W), .OP_W(OP_W), .CNT_W(CNT_W), .SEED(SEED)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .ev_valid_i(ev_v), .ev_addr_i(ev_a),
        .ev_opidx_i(ev_o), .clr_i(clr), .smp_addr_o(s_a), .smp_opidx_o(s_o),
        .smp_valid_o(s_v), .ev_count_o(s_c)
    );

    // R6 reference generator, built from the stated shift and taps
    logic [31:0] g_m;
    always @(posedge clk) begin
        if (!rst_n) g_m <= SEED;
        else        g_m <= {g_m[30:0], g_m[31] ^ g_m[21] ^ g_m[1] ^ g_m[0]};
    end

    // reference state
    logic [CNT_W-1:0]  m_c = '0;
    logic              m_v = 1'b0;
    logic [ADDR_W-1:0] m_a = '0;
    logic [OP_W-1:0]   m_o = '0;

    typedef struct packed {
        logic              v;
        logic              c;
        logic [ADDR_W-1:0] a;
        logic [OP_W-1:0]   o;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0, 32'h0000_1000, 2'd1},
        '{1'b0, 1'b0, 32'hDEAD_0000, 2'd3},
        '{1'b1, 1'b0, 32'h0000_2004, 2'd2},
        '{1'b1, 1'b0, 32'h0000_3008, 2'd0},
        '{1'b1, 1'b0, 32'h0000_400C, 2'd3},
        '{1'b0, 1'b0, 32'h0000_0000, 2'd0},
        '{1'b1, 1'b0, 32'h0000_5010, 2'd1},
        '{1'b1, 1'b0, 32'h0000_6014, 2'd2},
        '{1'b1, 1'b0, 32'h0000_7018, 2'd3},
        '{1'b1, 1'b0, 32'h0000_801C, 2'd0},
        '{1'b0, 1'b1, 32'h0000_0000, 2'd0},
        '{1'b1, 1'b0, 32'hCAFE_0040, 2'd2},
        '{1'b1, 1'b0, 32'hCAFE_0044, 2'd1},
        '{1'b1, 1'b1, 32'hBAD0_0048, 2'd3},
        '{1'b1, 1'b0, 32'hCAFE_004C, 2'd3},
        '{1'b1, 1'b0, 32'hCAFE_0050, 2'd0}
    };

    task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Drives one cycle, predicts the result, checks after the edge.
    task automatic step(input logic v, input logic c, input logic [ADDR_W-1:0] a, input logic [OP_W-1:0] o);
        logic [CNT_W-1:0] n, mk;
        string rq, rc;
        ev_v = v; clr = c; ev_a = a; ev_o = o;
        rq = "R7"; rc = "R7";
        if (c) begin
            m_c = '0; m_v = 1'b0; m_a = '0; m_o = '0; rq = "R8"; rc = "R8";
        end else if (v) begin
            n  = (m_c == CMAX) ? CMAX : m_c + 1'b1;
            rc = (m_c == CMAX) ? "R3" : "R2";
            rq = (m_c == '0) ? "R4" : "R5";
            mk = '0;
            for (int i = 1; i < int'(CNT_W); i++) if (n[i]) mk = CNT_W'((1 << i) - 1);
            if ((g_m[CNT_W-1:0] & mk) == '0) begin
                m_v = 1'b1; m_a = a; m_o = o;
            end
            m_c = n;
        end
        @(posedge clk);
        @(negedge clk);
        chk(rc, "count", 64'(s_c), 64'(m_c));
        chk(rq, "valid", 64'(s_v), 64'(m_v));
        chk(rq, "addr",  64'(s_a), 64'(m_a));
        chk(rq, "opidx", 64'(s_o), 64'(m_o));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: state in reset and right after release
        chk("R1", "count", 64'(s_c), 64'd0);
        chk("R1", "valid", 64'(s_v), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "addr",  64'(s_a), 64'd0);
        chk("R1", "opidx", 64'(s_o), 64'd0);

        for (int k = 0; k < NV; k++) step(VEC[k].v, VEC[k].c, VEC[k].a, VEC[k].o);

        // R4: first event after clear always captured
        step(1'b0, 1'b1, '0, '0);
        step(1'b1, 1'b0, 32'h0BAD_F00D, 2'd2);
        chk("R4", "addr direct", 64'(s_a), 64'h0BAD_F00D);

        // R3: drive well past the ceiling with varied addresses
        for (int k = 0; k < 40; k++) step(1'b1, 1'b0, 32'h1000_0000 + 32'(k * 4), 2'(k));
        chk("R3", "count at ceiling", 64'(s_c), 64'(CMAX));
        // R9: valid still held after many events
        chk("R9", "valid sticky", 64'(s_v), 64'd1);

        // R7: idle cycles change nothing
        for (int k = 0; k < 3; k++) step(1'b0, 1'b0, 32'hFFFF_FFFF, 2'd3);

        // R8: clear wins over a same-cycle event
        step(1'b1, 1'b1, 32'h7777_7777, 2'd1);
        chk("R8", "count after clear+event", 64'(s_c), 64'd0);

        // R5: long run of events exercising many mask widths
        for (int k = 0; k < 200; k++) begin
            if (k % 50 == 0) step(1'b0, 1'b1, '0, '0);
            step(k % 7 != 3, 1'b0, 32'h2000_0000 ^ 32'(k * 32'h0101), 2'(k >> 1));
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule